// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital side of a successive-approximation converter. It divides the peripheral clock by a power of two to form a conversion tick, then, on each tick, proposes a trial level to an external DAC and keeps or drops that trial bit depending on an external comparator. After the chosen number of result bits (plus two extra ticks when correction is on) it formats the code into a 16-bit result word, raises a one-cycle done pulse and a ready flag, and, in free-running mode, starts the next conversion at once.

A single 16-bit control word selects the divide ratio, the resolution, correction, free-running, alignment and differential interpretation. Writes to the control word land in a held copy straight away, but the copy that steers a conversion is taken only when a conversion starts. This keeps the divider and the bit count steady for the whole of a conversion. Correction subtracts a signed calibration offset, scales the result by an unsigned gain and clamps it to the range of the selected resolution.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, `result` is 0, and `busy`, `done` and `res_ready` are low. Only control bits 10:8 and 5:0 are stored. Written values in bits 15:11 and 7:6 read back as 0.
- R2: Prescale field bits 10:8 holding code p gives a tick every 4·2^p peripheral cycles. With T ticks in a conversion, `done` is high in the cycle that begins T·4·2^p + 1 rising edges after the start request was driven.
- R3: Resolution field bits 5:4 selects 12 bits (code 0), 10 bits (code 2) or 8 bits (code 3). The code is floor(input level / 2^(12−n)), right-aligned and zero-extended when bit 1 is 0.
- R4: Resolution code 1 behaves exactly like 12 bits.
- R5: With bit 1 set, the most significant result bit is placed at `result[15]` and the bits below the code are zero.
- R6: With bit 0 set, the value is code − 2^(n−1) in two's complement. When right-aligned it is sign-extended to 16 bits.
- R7: With bit 3 set, the value is ((v − offset) · gain) >>> 11, where offset is `offset_cal` taken as signed and gain is `gain_cal` taken as unsigned 1.11. The value is clamped to [0, 2^n−1], or to [−2^(n−1), 2^(n−1)−1] in differential mode.
- R8: With bit 3 set, a conversion takes n + 2 ticks instead of n.
- R9: With bit 2 of the held control word set when `done` is high, the next conversion starts on the following edge without a start request.
- R10: With bit 2 clear, one start request gives exactly one conversion, and a start request while `busy` is ignored.
- R11: A control write during a conversion reads back at once but does not change that conversion. It takes effect at the next start.
- R12: `done` is high for exactly one cycle and sets `res_ready`. A cycle with `res_rd` high clears `res_ready` unless a result is written in that same cycle.
- R13: The first trial level after a start is mid-scale (0x800). Each tick settles one bit, from the MSB down, and the bit is kept when `cmp_in` is high (input at or above the trial).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Held control word read-back |
| start | input | 1 | Conversion start request |
| cmp_in | input | 1 | Comparator: input at or above trial level |
| dac_code | output | 12 | Trial level driven to the DAC |
| offset_cal | input | 12 | Signed offset calibration |
| gain_cal | input | 12 | Unsigned 1.11 gain calibration |
| res_rd | input | 1 | Result read strobe |
| result | output | 16 | Formatted conversion result |
| res_ready | output | 1 | Unread result present |
| done | output | 1 | One-cycle conversion complete pulse |
| busy | output | 1 | Conversion in progress |

## Verification
A wrong bit decision or a step counter out of place shows up on `dac_code` within one tick of the fault. The final `result` is also off by a predictable power of two. A stale or early-loaded active configuration shows either as a wrong done latency, counted to the exact cycle against the divide ratio and tick count, or as a result in the wrong alignment or sign for the conversion in flight. Errors in the correction and format path are only visible on the `result` word of the conversion in which they occur. The clamp corners and the negative differential values are chosen so that a sign or width slip changes the upper result bits.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  localparam int CAL_W     = 12;
  localparam int GAIN_FRAC = 11;
  localparam int CORR_TICKS = 2;
  localparam logic [15:0] CFG_KEEP = 16'h073F;

  // control word layout
  typedef struct packed {
    logic [4:0] pad_hi;
    logic [2:0] psc;
    logic [1:0] pad_lo;
    logic [1:0] res;
    logic       corr;
    logic       free;
    logic       left;
    logic       diff;
  } cfg_t;

  // resolution code to bit count; code 1 falls back to 12 bits
  function automatic int res_bits(logic [1:0] code);
    case (code)
      2'd2:    return 10;
      2'd3:    return 8;
      default: return 12;
    endcase
  endfunction

  // offset, gain and clamp on a signed or unsigned value of nb bits
  function automatic int corr_value(int v, int off, int gain, int nb, logic diff);
    int p, lo, hi;
    p  = ((v - off) * gain) >>> GAIN_FRAC;
    lo = diff ? -(1 << (nb - 1)) : 0;
    hi = diff ? (1 << (nb - 1)) - 1 : (1 << nb) - 1;
    if (p < lo) p = lo;
    else if (p > hi) p = hi;
    return p;
  endfunction

  // right alignment keeps the two's-complement extension; left shifts it out
  function automatic logic [15:0] fmt_result(int y, int nb, logic left);
    logic [15:0] w;
    w = 16'(y);
    if (left) w = w << (16 - nb);
    return w;
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int SEL_W    = 3,
  parameter int BASE_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'((1 << (BASE_LOG + int'(sel))) - 1);
    tick = en && (cnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (en)       cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int W      = 12,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic              cmp_in,
  input  logic [STEP_W-1:0] nb,
  input  logic [STEP_W-1:0] total,
  output logic [W-1:0]      dac_code,
  output logic [W-1:0]      code_nx,
  output logic              last
);
  logic [STEP_W-1:0] step_q;
  logic [W-1:0]      sar_q;
  logic [W-1:0]      bitm;
  logic [W-1:0]      trial;
  logic              testing;

  always_comb begin
    testing  = step_q < nb;
    bitm     = testing ? (W'(1) << (nb - STEP_W'(1) - step_q)) : '0;
    trial    = sar_q | bitm;
    dac_code = trial << (W - int'(nb));
    code_nx  = (tick && testing && cmp_in) ? trial : sar_q;
    last     = tick && (step_q == total - STEP_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      step_q <= '0;
      sar_q  <= '0;
    end else if (tick) begin
      step_q <= step_q + 1'b1;
      sar_q  <= code_nx;
    end
  end
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
#(
  parameter int DAC_W  = 12,
  parameter int STEP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             start,
  input  logic             cmp_in,
  output logic [DAC_W-1:0] dac_code,
  input  logic [CAL_W-1:0] offset_cal,
  input  logic [CAL_W-1:0] gain_cal,
  input  logic             res_rd,
  output logic [15:0]      result,
  output logic             res_ready,
  output logic             done,
  output logic             busy
);
  cfg_t cfg_pend_q, cfg_act_q;

  logic              conv_go;
  logic              conv_fin;
  logic              tick;
  logic [STEP_W-1:0] nb_act, total_act;
  logic [DAC_W-1:0]  raw_code;
  logic [15:0]       res_nx;
  int                nb_i, v_i, y_i;

  assign conv_go   = !busy && (start || (done && cfg_pend_q.free));
  assign cfg_rdata = cfg_pend_q;

  always_comb begin
    nb_i      = res_bits(cfg_act_q.res);
    nb_act    = STEP_W'(nb_i);
    total_act = nb_act + (cfg_act_q.corr ? STEP_W'(CORR_TICKS) : '0);
    v_i       = int'(raw_code);
    if (cfg_act_q.diff) v_i = v_i - (1 << (nb_i - 1));
    y_i = cfg_act_q.corr
        ? corr_value(v_i, int'($signed(offset_cal)), int'(gain_cal), nb_i, cfg_act_q.diff)
        : v_i;
    res_nx = fmt_result(y_i, nb_i, cfg_act_q.left);
  end

  adc_clk_div #(.SEL_W(3), .BASE_LOG(2)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (conv_go),
    .en    (busy),
    .sel   (cfg_act_q.psc),
    .tick  (tick)
  );

  adc_sar_core #(.W(DAC_W), .STEP_W(STEP_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (conv_go),
    .tick     (tick),
    .cmp_in   (cmp_in),
    .nb       (nb_act),
    .total    (total_act),
    .dac_code (dac_code),
    .code_nx  (raw_code),
    .last     (conv_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_pend_q <= '0;
      cfg_act_q  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
      res_ready  <= 1'b0;
    end else begin
      if (cfg_wr)  cfg_pend_q <= cfg_t'(cfg_wdata & CFG_KEEP);
      if (conv_go) cfg_act_q  <= cfg_pend_q;
      if (conv_go)       busy <= 1'b1;
      else if (conv_fin) busy <= 1'b0;
      done <= conv_fin;
      if (conv_fin) result <= res_nx;
      if (conv_fin)    res_ready <= 1'b1;
      else if (res_rd) res_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sar_ctrl_chk.sv
module adc_sar_ctrl_chk #(
  parameter int DAC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             fin,
  input logic             busy,
  input logic             done,
  input logic             res_ready,
  input logic             res_rd,
  input logic [15:0]      result,
  input logic [15:0]      cfg_act,
  input logic [15:0]      cfg_held,
  input logic [DAC_W-1:0] dac_code
);
  // R12: done lasts one cycle and marks a result as ready
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r12_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n) done |-> res_ready);
  a_r12_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !fin) |=> !res_ready);
  // R2: completion ends the busy window
  a_r2_fin_in_busy: assert property (@(posedge clk) disable iff (!rst_n) fin |-> busy);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R11: active settings move only at a conversion start
  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n) !go |=> $stable(cfg_act));
  // R13: first trial is mid-scale
  a_r13_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (dac_code == {1'b1, {(DAC_W-1){1'b0}}}));
  // R9: free-running restart
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_held[2]) |=> busy);
  // R5: left-aligned 8-bit result leaves the low byte clear
  a_r5_left_low: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_act[1] && cfg_act[5:4] == 2'b11) |-> (result[7:0] == 8'h00));
  // R3: right-aligned single-ended 8-bit result leaves the high byte clear
  a_r3_right_high: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_act[1] && !cfg_act[0] && cfg_act[5:4] == 2'b11) |-> (result[15:8] == 8'h00));
  // R10: a start request is never taken while busy
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy);
endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(.DAC_W(DAC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (conv_go),
  .fin       (conv_fin),
  .busy      (busy),
  .done      (done),
  .res_ready (res_ready),
  .res_rd    (res_rd),
  .result    (result),
  .cfg_act   (cfg_act_q),
  .cfg_held  (cfg_pend_q),
  .dac_code  (dac_code)
);

// File: tb/adc_sar_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_sar_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        start = 1'b0;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic [11:0] offset_cal = '0;
  logic [11:0] gain_cal = 12'h800;
  logic        res_rd = 1'b0;
  logic [15:0] result;
  logic        res_ready, done, busy;
  logic [11:0] ain = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // comparator model: analog level at or above trial
  assign cmp_in = (ain >= dac_code);

  adc_sar_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .start(start), .cmp_in(cmp_in), .dac_code(dac_code), .offset_cal(offset_cal),
    .gain_cal(gain_cal), .res_rd(res_rd), .result(result), .res_ready(res_ready),
    .done(done), .busy(busy)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [11:0] lvl;
    logic [11:0] off;
    logic [11:0] gain;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 12'hABC, 12'h000, 12'h800, 16'h0ABC},  // R3 12-bit right
    '{16'h0002, 12'hABC, 12'h000, 12'h800, 16'hABC0},  // R5 12-bit left
    '{16'h0020, 12'hABC, 12'h000, 12'h800, 16'h02AF},  // R3 10-bit
    '{16'h0030, 12'hABC, 12'h000, 12'h800, 16'h00AB},  // R3 8-bit
    '{16'h0032, 12'hABC, 12'h000, 12'h800, 16'hAB00},  // R5 8-bit left
    '{16'h0010, 12'h123, 12'h000, 12'h800, 16'h0123},  // R4 code 1
    '{16'h0001, 12'h900, 12'h000, 12'h800, 16'h0100},  // R6 positive
    '{16'h0001, 12'h700, 12'h000, 12'h800, 16'hFF00},  // R6 negative
    '{16'h0003, 12'h700, 12'h000, 12'h800, 16'hF000},  // R6 left negative
    '{16'h0031, 12'h100, 12'h000, 12'h800, 16'hFF90},  // R6 8-bit negative
    '{16'h0008, 12'h400, 12'h010, 12'h800, 16'h03F0},  // R7 offset
    '{16'h0008, 12'h400, 12'h000, 12'hC00, 16'h0600},  // R7 gain 1.5
    '{16'h0008, 12'hF00, 12'h000, 12'hC00, 16'h0FFF},  // R7 clamp high
    '{16'h0008, 12'h005, 12'h010, 12'h800, 16'h0000},  // R7 clamp low
    '{16'h0009, 12'h700, 12'h000, 12'h400, 16'hFF80},  // R7 diff gain 0.5
    '{16'h0038, 12'hFFF, 12'h000, 12'h800, 16'h00FF},  // R7 8-bit range
    '{16'h0009, 12'h000, 12'h7FF, 12'h800, 16'hF800}   // R7 diff clamp low
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] c);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = c;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // pulse start, count rising edges until done is seen high
  task automatic run_conv(output int cyc);
    @(negedge clk); start = 1'b1;
    @(posedge clk); cyc = 1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 6000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic read_result();
    @(negedge clk); res_rd = 1'b1;
    @(negedge clk); res_rd = 1'b0;
  endtask

  initial begin
    int cyc;
    int dn;
    bit dbl;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cfg", 32'(cfg_rdata), 32'h0000);
    check("R1 result", 32'(result), 32'h0);
    check("R1 flags", {29'b0, busy, done, res_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reserved bits read back as zero
    write_cfg(16'hFFFF);
    check("R1 reserved", 32'(cfg_rdata), 32'h073F);

    // table walk: R3 R4 R5 R6 R7 and R12 ready handling
    for (int i = 0; i < NV; i++) begin
      write_cfg(VECS[i].cfg);
      ain = VECS[i].lvl; offset_cal = VECS[i].off; gain_cal = VECS[i].gain;
      run_conv(cyc);
      check($sformatf("vector %0d result", i), 32'(result), 32'(VECS[i].exp));
      check("R12 ready set", 32'(res_ready), 32'h1);
      read_result();
      check("R12 ready clear", 32'(res_ready), 32'h0);
    end
    offset_cal = '0; gain_cal = 12'h800;

    // R2: done latency against divide ratio
    ain = 12'h555;
    write_cfg(16'h0000); run_conv(cyc); check("R2 div4 12-bit", 32'(cyc), 32'd49); read_result();
    write_cfg(16'h0230); run_conv(cyc); check("R2 div16 8-bit", 32'(cyc), 32'd129); read_result();
    write_cfg(16'h0730); run_conv(cyc); check("R2 div512 8-bit", 32'(cyc), 32'd4097); read_result();
    // R8: correction adds two ticks
    write_cfg(16'h0038); run_conv(cyc); check("R8 8-bit corr", 32'(cyc), 32'd41); read_result();
    write_cfg(16'h0008); run_conv(cyc); check("R8 12-bit corr", 32'(cyc), 32'd57);
    check("R8 result", 32'(result), 32'h0555); read_result();

    // R13: first trial mid-scale, rejected MSB moves to next bit
    write_cfg(16'h0000); ain = 12'h3FF;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R13 first trial", 32'(dac_code), 32'h800);
    repeat (4) @(negedge clk);
    check("R13 second trial", 32'(dac_code), 32'h400);
    while (!done) @(negedge clk);
    check("R13 result", 32'(result), 32'h03FF); read_result();

    // R10: single mode, repeat start while busy ignored
    ain = 12'hABC; dn = 0; cyc = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (done) begin dn++; if (cyc == 0) cyc = k + 13; end
    end
    check("R10 one conversion", 32'(dn), 32'd1);
    check("R10 latency kept", 32'(cyc), 32'd49);
    check("R10 idle", 32'(busy), 32'h0);
    read_result();

    // R11: write during conversion is held until next start
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 16'h0002;
    @(negedge clk); cfg_wr = 1'b0;
    check("R11 readback", 32'(cfg_rdata), 32'h0002);
    while (!done) @(negedge clk);
    check("R11 old format", 32'(result), 32'h0ABC); read_result();
    run_conv(cyc);
    check("R11 new format", 32'(result), 32'hABC0); read_result();

    // R9: free-running restart, stopped by clearing the bit
    write_cfg(16'h0004); dn = 0; dbl = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 250; k++) begin
      if (k == 110) cfg_wr = 1'b1;
      cfg_wdata = 16'h0000;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (done) begin
        dn++;
        @(negedge clk);
        if (done) dbl = 1'b1;
      end
    end
    check("R9 conversion count", 32'(dn), 32'd3);
    check("R9 stopped", 32'(busy), 32'h0);
    check("R12 done width", 32'(dbl), 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule